// File: doc/BRIEF.md
# LIN-Capable UART Status and Interrupt Unit

This block keeps the status flags of a UART receiver and transmitter and drives the two interrupt request lines. The serialiser, the baud generator and the register file sit around it. They report events to it as single-cycle strobes: a byte was received, a receive error occurred, the receive data register was read, the transmit data register was written, or the transmit shift register was loaded. Register writes that touch the clear bits arrive as strobes as well. Each flag follows its own clear rule:

- The receive-full flag clears when the receive data register is read.
- The three error flags clear together through a write-1 group clear.
- The break flag clears when 0 is written to it.
- The transmit-empty flag clears only when the transmit data register is written.

When the unit acts as a LIN slave (mode 3) with reception switched off, it also watches the serial input for a break. A break is the line held low for at least 11 bit times, counted on the baud tick. If a set event and a clear event for the same flag arrive in the same cycle, the set wins.

Top module: `lin_uart_stat_irq`

## Requirements
- R1: After the asynchronous reset rst_ni, and in the cycle after a soft_rst_i pulse, tx_empty_o is 1 and rx_full_o, ovr_o, frm_o, par_o and brk_o are all 0. soft_rst_i takes priority over every other event.
- R2: rx_full_o becomes 1 in the cycle after rx_done_i and becomes 0 in the cycle after rd_data_i. If both strobes come in the same cycle, it becomes 1.
- R3: ovr_o, frm_o and par_o are each set by ovr_err_i, frm_err_i and par_err_i respectively. An err_clr_i pulse clears all three in the next cycle. A flag whose set strobe coincides with err_clr_i becomes 1.
- R4: rx_irq_o is 1 exactly when rx_ie_i is 1 and at least one of rx_full_o, ovr_o, frm_o, par_o or brk_o is 1.
- R5: While break detection is active, brk_o becomes 1 in the cycle after the 11th bit_tick_i during which sin_i has stayed 0 without interruption. After 10 such ticks it stays 0.
- R6: Break detection is active only when mode_i equals 2'b11 and rx_en_i is 0. In any other mode, or while reception is enabled, low ticks are not counted and brk_o does not set.
- R7: A 1 on sin_i restarts the low-time count from zero. brk_o sets at most once per low period: if it is cleared while sin_i stays low, further ticks do not set it again until sin_i has returned to 1.
- R8: brk_o clears in the cycle after brk_wr_i with brk_wr_val_i = 0. A write with value 1 has no effect. A break set in the same cycle as a clearing write wins.
- R9: tx_empty_o becomes 0 only in the cycle after wr_data_i and becomes 1 in the cycle after sr_load_i. Both strobes together give 1. rd_data_i and all the other inputs leave it unchanged.
- R10: tx_irq_o is 1 exactly when tx_ie_i is 1 and tx_empty_o is 1, in every mode. This means enabling tx_ie_i right after reset raises the request at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous software reset pulse |
| sin_i | input | 1 | Serial input line |
| bit_tick_i | input | 1 | One pulse per bit time |
| mode_i | input | 2 | Operating mode; 2'b11 is LIN slave |
| rx_en_i | input | 1 | Receive enable |
| rx_ie_i | input | 1 | Receive interrupt enable |
| tx_ie_i | input | 1 | Transmit interrupt enable |
| rd_data_i | input | 1 | Receive data register read strobe |
| wr_data_i | input | 1 | Transmit data register write strobe |
| sr_load_i | input | 1 | Transmit shift register load strobe |
| rx_done_i | input | 1 | Received byte ready strobe |
| ovr_err_i | input | 1 | Overrun error strobe |
| frm_err_i | input | 1 | Framing error strobe |
| par_err_i | input | 1 | Parity error strobe |
| err_clr_i | input | 1 | Write of 1 to the error group clear bit |
| brk_wr_i | input | 1 | Write strobe to the break flag bit |
| brk_wr_val_i | input | 1 | Value written to the break flag bit |
| rx_full_o | output | 1 | Receive data full flag |
| ovr_o | output | 1 | Overrun error flag |
| frm_o | output | 1 | Framing error flag |
| par_o | output | 1 | Parity error flag |
| brk_o | output | 1 | LIN break detected flag |
| tx_empty_o | output | 1 | Transmit data register empty flag |
| rx_irq_o | output | 1 | Receive interrupt request |
| tx_irq_o | output | 1 | Transmit interrupt request |

## Verification
On every cycle, the assertions check the cycle-after effect of each set and clear strobe, including the rule that a set wins over a clear. They also check that the low-time counter stays within its saturation bound and that a break flag only rises while detection was active and the line was low. Only the bench scenarios can show the exact tick count at which a break is declared. They also cover these cases:

- Gating by mode and by receive enable.
- The rule that a break sets at most once per low period.
- The restart when the line goes high.
- The interrupt outputs under combinations of enables and flags.

// File: rtl/lin_uart_stat_pkg.sv
package lin_uart_stat_pkg;
  localparam logic [1:0] MODE_LIN_SLAVE = 2'b11;
  localparam int unsigned BRK_BITS_DEF = 11;

  typedef struct packed {
    logic ovr;
    logic frm;
    logic par;
  } err_flags_t;
endpackage

// File: rtl/lin_brk_det.sv
module lin_brk_det #(
  parameter int unsigned BRK_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic active_i,
  input  logic sin_i,
  input  logic tick_i,
  input  logic wr_i,
  input  logic wr_val_i,
  output logic brk_o
);
  localparam int unsigned CNT_W = $clog2(BRK_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(BRK_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BRK_BITS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             set_w;
  logic             brk_q;

  // Counter sticks at CNT_SAT until the line goes high: one set per low period.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (soft_rst_i || !active_i || sin_i) cnt_q <= '0;
    else if (tick_i && cnt_q != CNT_SAT)    cnt_q <= cnt_q + 1'b1;
  end

  assign set_w = active_i && !sin_i && tick_i && (cnt_q == CNT_LAST) && !soft_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                brk_q <= 1'b0;
    else if (soft_rst_i)        brk_q <= 1'b0;
    else if (set_w)             brk_q <= 1'b1;
    else if (wr_i && !wr_val_i) brk_q <= 1'b0;
  end

  assign brk_o = brk_q;

  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_SAT);
  // R6
  brk_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_q) |-> $past(active_i) && !$past(sin_i) && $past(tick_i));
  // R8
  brk_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !wr_val_i && !set_w |=> !brk_q);
  // R8
  brk_w1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_q && !soft_rst_i && !(wr_i && !wr_val_i) |=> brk_q);
endmodule

// File: rtl/lin_rx_flags.sv
module lin_rx_flags
  import lin_uart_stat_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       soft_rst_i,
  input  logic       rx_done_i,
  input  logic       rd_data_i,
  input  err_flags_t err_set_i,
  input  logic       err_clr_i,
  output logic       rx_full_o,
  output err_flags_t err_o
);
  logic       full_q;
  err_flags_t err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         full_q <= 1'b0;
    else if (soft_rst_i) full_q <= 1'b0;
    else if (rx_done_i)  full_q <= 1'b1;
    else if (rd_data_i)  full_q <= 1'b0;
  end

  for (genvar g = 0; g < 3; g++) begin : g_err
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               err_q[g] <= 1'b0;
      else if (soft_rst_i)       err_q[g] <= 1'b0;
      else if (err_set_i[g])     err_q[g] <= 1'b1;
      else if (err_clr_i)        err_q[g] <= 1'b0;
    end
  end

  assign rx_full_o = full_q;
  assign err_o     = err_q;

  // R2
  full_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_i && !soft_rst_i |=> full_q);
  // R2
  full_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_i && !rx_done_i |=> !full_q);
  // R3
  err_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i && err_set_i == '0 |=> err_q == '0);
  // R3
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_rst_i |=> (err_q & $past(err_set_i)) == $past(err_set_i));
endmodule

// File: rtl/lin_tx_flags.sv
module lin_tx_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic wr_data_i,
  input  logic sr_load_i,
  output logic tx_empty_o
);
  logic empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         empty_q <= 1'b1;
    else if (soft_rst_i) empty_q <= 1'b1;
    else if (sr_load_i)  empty_q <= 1'b1;
    else if (wr_data_i)  empty_q <= 1'b0;
  end

  assign tx_empty_o = empty_q;

  // R9
  empty_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(empty_q) |-> $past(wr_data_i));
  // R9
  empty_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_load_i |=> empty_q);
  // R1
  soft_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> empty_q);
endmodule

// File: rtl/lin_uart_stat_irq.sv
module lin_uart_stat_irq
  import lin_uart_stat_pkg::*;
#(
  parameter int unsigned BRK_BITS = BRK_BITS_DEF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       soft_rst_i,
  input  logic       sin_i,
  input  logic       bit_tick_i,
  input  logic [1:0] mode_i,
  input  logic       rx_en_i,
  input  logic       rx_ie_i,
  input  logic       tx_ie_i,
  input  logic       rd_data_i,
  input  logic       wr_data_i,
  input  logic       sr_load_i,
  input  logic       rx_done_i,
  input  logic       ovr_err_i,
  input  logic       frm_err_i,
  input  logic       par_err_i,
  input  logic       err_clr_i,
  input  logic       brk_wr_i,
  input  logic       brk_wr_val_i,
  output logic       rx_full_o,
  output logic       ovr_o,
  output logic       frm_o,
  output logic       par_o,
  output logic       brk_o,
  output logic       tx_empty_o,
  output logic       rx_irq_o,
  output logic       tx_irq_o
);
  err_flags_t err_set, err_q;
  logic       brk_active;

  assign err_set    = '{ovr: ovr_err_i, frm: frm_err_i, par: par_err_i};
  assign brk_active = (mode_i == MODE_LIN_SLAVE) && !rx_en_i;

  lin_rx_flags u_rx (
    .clk_i, .rst_ni, .soft_rst_i,
    .rx_done_i, .rd_data_i,
    .err_set_i (err_set),
    .err_clr_i,
    .rx_full_o,
    .err_o     (err_q)
  );

  lin_tx_flags u_tx (
    .clk_i, .rst_ni, .soft_rst_i,
    .wr_data_i, .sr_load_i,
    .tx_empty_o
  );

  lin_brk_det #(.BRK_BITS(BRK_BITS)) u_brk (
    .clk_i, .rst_ni, .soft_rst_i,
    .active_i (brk_active),
    .sin_i,
    .tick_i   (bit_tick_i),
    .wr_i     (brk_wr_i),
    .wr_val_i (brk_wr_val_i),
    .brk_o
  );

  assign ovr_o = err_q.ovr;
  assign frm_o = err_q.frm;
  assign par_o = err_q.par;

  assign rx_irq_o = rx_ie_i && (rx_full_o || ovr_o || frm_o || par_o || brk_o);
  assign tx_irq_o = tx_ie_i && tx_empty_o;

  // R10
  tx_irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> tx_ie_i);
  // R4
  rx_irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> rx_ie_i);
  // R6
  brk_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_o) |-> $past(mode_i) == MODE_LIN_SLAVE && !$past(rx_en_i));
endmodule

// File: tb/lin_uart_stat_irq_test.sv
module lin_uart_stat_irq_test;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic soft_rst = 0, sin = 1, tick = 0, rx_en = 0, rx_ie = 0, tx_ie = 0;
  logic [1:0] mode = 2'b11;
  logic rd = 0, wr = 0, ld = 0, done = 0, oe = 0, fe = 0, pe = 0, eclr = 0, bwr = 0, bval = 0;
  logic rx_full, ovr, frm, par, brk, tx_empty, rx_irq, tx_irq;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_uart_stat_irq uut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .sin_i(sin), .bit_tick_i(tick),
    .mode_i(mode), .rx_en_i(rx_en), .rx_ie_i(rx_ie), .tx_ie_i(tx_ie),
    .rd_data_i(rd), .wr_data_i(wr), .sr_load_i(ld), .rx_done_i(done),
    .ovr_err_i(oe), .frm_err_i(fe), .par_err_i(pe), .err_clr_i(eclr),
    .brk_wr_i(bwr), .brk_wr_val_i(bval),
    .rx_full_o(rx_full), .ovr_o(ovr), .frm_o(frm), .par_o(par), .brk_o(brk),
    .tx_empty_o(tx_empty), .rx_irq_o(rx_irq), .tx_irq_o(tx_irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Strobes are driven for one cycle, from one negedge to the next.
  task automatic idle(); @(negedge clk); endtask
  task automatic clear_strobes();
    {soft_rst, tick, rd, wr, ld, done, oe, fe, pe, eclr, bwr, bval} = '0;
  endtask
  task automatic step(); @(negedge clk); clear_strobes(); endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin tick = 1; step(); end
  endtask

  task automatic t_reset();
    chk("R1 tx_empty", tx_empty, 1'b1);
    chk("R1 rx_full", rx_full, 1'b0);
    chk("R1 errs", ovr | frm | par, 1'b0);
    chk("R1 brk", brk, 1'b0);
    tx_ie = 1; #1;
    chk("R10 immediate", tx_irq, 1'b1);
    tx_ie = 0; #1;
    chk("R10 gated", tx_irq, 1'b0);
  endtask

  task automatic t_rx_full();
    done = 1; step();
    chk("R2 set", rx_full, 1'b1);
    chk("R4 ie off", rx_irq, 1'b0);
    rx_ie = 1; #1;
    chk("R4 full irq", rx_irq, 1'b1);
    rd = 1; step();
    chk("R2 read clr", rx_full, 1'b0);
    chk("R4 irq drop", rx_irq, 1'b0);
    rd = 1; done = 1; step();
    chk("R2 set wins", rx_full, 1'b1);
    rd = 1; step();
    rx_ie = 0;
  endtask

  task automatic t_errors();
    oe = 1; step();
    chk("R3 ovr", ovr, 1'b1);
    chk("R3 others", frm | par, 1'b0);
    fe = 1; pe = 1; step();
    chk("R3 frm", frm, 1'b1);
    chk("R3 par", par, 1'b1);
    rd = 1; step();
    chk("R3 read no clr", ovr, 1'b1);
    rx_ie = 1; #1;
    chk("R4 err irq", rx_irq, 1'b1);
    eclr = 1; step();
    chk("R3 group clr", ovr | frm | par, 1'b0);
    chk("R4 no irq", rx_irq, 1'b0);
    oe = 1; fe = 1; step();
    eclr = 1; fe = 1; step();
    chk("R3 set wins frm", frm, 1'b1);
    chk("R3 ovr clr", ovr, 1'b0);
    eclr = 1; step();
    rx_ie = 0;
  endtask

  task automatic t_tx();
    rd = 1; ld = 0; step();
    chk("R9 rd no effect", tx_empty, 1'b1);
    wr = 1; step();
    chk("R9 wr clr", tx_empty, 1'b0);
    tx_ie = 1; #1;
    chk("R10 low flag", tx_irq, 1'b0);
    mode = 2'b00; rd = 1; eclr = 1; done = 1; step();
    chk("R9 others no set", tx_empty, 1'b0);
    ld = 1; step();
    chk("R9 load set", tx_empty, 1'b1);
    chk("R10 mode0 irq", tx_irq, 1'b1);
    wr = 1; ld = 1; step();
    chk("R9 set wins", tx_empty, 1'b1);
    mode = 2'b01; #1;
    chk("R10 mode1 irq", tx_irq, 1'b1);
    rd = 1; step();
    tx_ie = 0; mode = 2'b11;
  endtask

  task automatic t_break();
    mode = 2'b11; rx_en = 0; sin = 0;
    ticks(10);
    chk("R5 10 ticks", brk, 1'b0);
    ticks(1);
    chk("R5 11 ticks", brk, 1'b1);
    rx_ie = 1; #1;
    chk("R4 brk irq", rx_irq, 1'b1);
    bwr = 1; bval = 1; step();
    chk("R8 write1 keeps", brk, 1'b1);
    bwr = 1; bval = 0; step();
    chk("R8 write0 clr", brk, 1'b0);
    ticks(15);
    chk("R7 no re-set while low", brk, 1'b0);
    sin = 1; step();
    sin = 0; ticks(6);
    sin = 1; step();
    sin = 0; ticks(10);
    chk("R7 restart count", brk, 1'b0);
    ticks(1);
    chk("R7 rearmed", brk, 1'b1);
    bwr = 1; step();
    sin = 1; step();
    sin = 0; ticks(10);
    tick = 1; bwr = 1; bval = 0; step();
    chk("R8 set wins", brk, 1'b1);
    bwr = 1; step();
    sin = 1; step();
    rx_ie = 0;
  endtask

  task automatic t_break_gate();
    mode = 2'b10; sin = 0;
    ticks(14);
    chk("R6 mode2", brk, 1'b0);
    mode = 2'b11; rx_en = 1;
    ticks(14);
    chk("R6 rx_en", brk, 1'b0);
    rx_en = 0;
    ticks(10);
    chk("R6 count from enable", brk, 1'b0);
    ticks(1);
    chk("R6 active", brk, 1'b1);
    sin = 1;
  endtask

  task automatic t_soft_rst();
    wr = 1; done = 1; oe = 1; step();
    soft_rst = 1; done = 1; ld = 0; step();
    chk("R1 soft tx_empty", tx_empty, 1'b1);
    chk("R1 soft rx_full", rx_full, 1'b0);
    chk("R1 soft err", ovr, 1'b0);
    chk("R1 soft brk", brk, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle();
    t_reset();
    t_rx_full();
    t_errors();
    t_tx();
    t_break();
    t_break_gate();
    t_soft_rst();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule